// File: doc/BRIEF.md
# I2S Master Audio Receiver

This block is the receive side of an I2S bus master. It drives the serial bit clock and the word-select line, samples the incoming serial data, and packs the received bits into 16-bit packets. The host collects each packet from a one-entry receive buffer through a simple read strobe. Status outputs show whether a packet is waiting, which audio channel it belongs to, and whether a packet was lost.

Standard I2S framing is used. Word-select low marks the left channel and high marks the right channel. The first data bit of a channel arrives one bit clock after word-select changes. The channel slot is either 16 or 32 bit clocks long. A 32-bit channel value reaches the host as two packets, most significant half first, and both packets carry the same channel-side bit. A packet that completes while the previous one is still unread is dropped and an overrun flag is raised. The host clears that flag by reading the data and then reading the status. Two interrupt outputs report a waiting packet and an overrun, and each has its own enable.

Top module: `i2s_master_rx`

## Requirements
- R1: While `enable` is high, `sck_out` toggles every `HALF_DIV` clock cycles. The first toggle after `enable` rises is a rising edge. While `enable` is low, `sck_out` and `ws_out` are held at 0 from the next cycle on.
- R2: `ws_out` changes only on falling edges of `sck_out`. At the k-th rising edge after enable (k = 0, 1, ...), `ws_out` equals (k / L) mod 2. L is 16 when `chan32` = 0 and 32 when `chan32` = 1. A value of 0 means the left channel.
- R3: Serial data is sampled on rising edges of `sck_out`, most significant bit first. The sample at rising edge 0 carries no data. Data bit j is taken at rising edge j+1. Bits 16n to 16n+15 form packet n, and the first of these is its bit 15 as it appears on `rd_data`.
- R4: When a packet completes with the buffer empty (or read in the same cycle), `rd_data` takes the packet and `rxne` is set. A pulse on `rd_en` with no packet arriving clears `rxne`.
- R5: `side` equals the `ws_out` level at the rising edge that sampled the packet's most significant bit. With `chan32` = 1, both packets of a channel have the same `side`, and the upper half-word is delivered first.
- R6: When a packet completes while `rxne` = 1 and `rd_en` is low, `ovr` is set. `rd_data`, `side` and `rxne` keep their values, and the new packet is discarded.
- R7: `ovr` clears only on an `st_rd` pulse that comes after an `rd_en` pulse made while `ovr` was set. An `st_rd` pulse without such a prior data read leaves `ovr` set.
- R8: `rx_irq` is high exactly when `rxne` and `rx_ie` are both high. `err_irq` is high exactly when `ovr` and `err_ie` are both high.
- R9: After reset, `sck_out`, `ws_out`, `rxne`, `ovr`, `rx_irq` and `err_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the bus clock and framing; low restarts the frame |
| chan32 | input | 1 | Channel slot length: 0 = 16 bits, 1 = 32 bits |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Overrun interrupt enable |
| rd_en | input | 1 | Host data read strobe |
| st_rd | input | 1 | Host status read strobe |
| sd_in | input | 1 | Serial audio data |
| sck_out | output | 1 | Serial bit clock |
| ws_out | output | 1 | Word select (0 = left, 1 = right) |
| rd_data | output | PKT_W | Receive buffer contents |
| rxne | output | 1 | Receive buffer holds an unread packet |
| side | output | 1 | Channel of the buffered packet |
| ovr | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Overrun interrupt |

## Verification
The bench builds the block with `HALF_DIV` = 2 and the default 16-bit packet, so each serial bit takes four system clocks. At that rate about twenty packets in each slot length fit in a few thousand cycles. That is enough to cover both channels, the change of word select at every slot boundary, and the all-zero and all-one bit patterns, with every expected word computed from the packet index. The small divider also makes the gap between packets short enough to time the overrun case and its two-step clear exactly.

// File: rtl/i2s_mrx_pkg.sv
package i2s_mrx_pkg;
    localparam int PKT_W = 16;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;
endpackage

// File: rtl/i2s_mrx_clkgen.sv
module i2s_mrx_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sck;
    } cg_t;

    cg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            st_d.sck = ~st_q.sck;
            rise     = ~st_q.sck;
            fall     = st_q.sck;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck = st_q.sck;
endmodule

// File: rtl/i2s_mrx_framer.sv
module i2s_mrx_framer
    import i2s_mrx_pkg::*;
#(
    parameter int PKT_W = i2s_mrx_pkg::PKT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             chan32,
    input  logic             rise,
    input  logic             fall,
    input  logic             sd_in,
    output logic             ws,
    output logic             pkt_valid,
    output logic [PKT_W-1:0] pkt_data,
    output side_e            pkt_side
);
    localparam int SLOT_W = $clog2(2 * PKT_W);
    localparam int BIT_W  = $clog2(PKT_W);
    localparam logic [SLOT_W-1:0] SLOT_LAST_S = SLOT_W'(PKT_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST_L = SLOT_W'(2 * PKT_W - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST    = BIT_W'(PKT_W - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot_bit;
        logic              ws;
        logic              ws_pend;
        logic              primed;
        logic [BIT_W-1:0]  bit_idx;
        logic [PKT_W-1:0]  shreg;
        logic              side_hold;
        logic              vld;
        logic [PKT_W-1:0]  data;
        logic              side;
    } fr_t;

    fr_t st_d, st_q;
    logic [SLOT_W-1:0] slot_last;
    logic [PKT_W-1:0]  shifted;
    logic              cur_side;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        slot_last = chan32 ? SLOT_LAST_L : SLOT_LAST_S;
        shifted   = {st_q.shreg[PKT_W-2:0], sd_in};
        cur_side  = (st_q.bit_idx == '0) ? st_q.ws : st_q.side_hold;
        if (!enable) begin
            st_d = '0;
        end else begin
            if (rise) begin
                if (st_q.slot_bit == slot_last) begin
                    st_d.slot_bit = '0;
                    st_d.ws_pend  = 1'b1;
                end else begin
                    st_d.slot_bit = st_q.slot_bit + 1'b1;
                end
                if (!st_q.primed) begin
                    st_d.primed = 1'b1;
                end else begin
                    st_d.shreg = shifted;
                    if (st_q.bit_idx == '0) st_d.side_hold = st_q.ws;
                    if (st_q.bit_idx == BIT_LAST) begin
                        st_d.vld     = 1'b1;
                        st_d.data    = shifted;
                        st_d.side    = cur_side;
                        st_d.bit_idx = '0;
                    end else begin
                        st_d.bit_idx = st_q.bit_idx + 1'b1;
                    end
                end
            end
            if (fall && st_q.ws_pend) begin
                st_d.ws      = ~st_q.ws;
                st_d.ws_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ws        = st_q.ws;
    assign pkt_valid = st_q.vld;
    assign pkt_data  = st_q.data;
    assign pkt_side  = side_e'(st_q.side);
endmodule

// File: rtl/i2s_mrx_rxbuf.sv
module i2s_mrx_rxbuf
    import i2s_mrx_pkg::*;
#(
    parameter int PKT_W = i2s_mrx_pkg::PKT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_data,
    input  side_e            pkt_side,
    input  logic             rd_en,
    input  logic             st_rd,
    output logic [PKT_W-1:0] rd_data,
    output logic             rxne,
    output logic             side,
    output logic             ovr
);
    typedef struct packed {
        logic [PKT_W-1:0] data;
        logic             rxne;
        logic             side;
        logic             ovr;
        logic             ovr_arm;
    } rb_t;

    rb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ovr && rd_en) st_d.ovr_arm = 1'b1;
        if (st_q.ovr_arm && st_rd) begin
            st_d.ovr     = 1'b0;
            st_d.ovr_arm = 1'b0;
        end
        if (pkt_valid) begin
            if (st_q.rxne && !rd_en) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.data = pkt_data;
                st_d.side = pkt_side;
                st_d.rxne = 1'b1;
            end
        end else if (rd_en) begin
            st_d.rxne = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;
    assign rxne    = st_q.rxne;
    assign side    = st_q.side;
    assign ovr     = st_q.ovr;
endmodule

// File: rtl/i2s_master_rx.sv
module i2s_master_rx
    import i2s_mrx_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int PKT_W    = i2s_mrx_pkg::PKT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             chan32,
    input  logic             rx_ie,
    input  logic             err_ie,
    input  logic             rd_en,
    input  logic             st_rd,
    input  logic             sd_in,
    output logic             sck_out,
    output logic             ws_out,
    output logic [PKT_W-1:0] rd_data,
    output logic             rxne,
    output logic             side,
    output logic             ovr,
    output logic             rx_irq,
    output logic             err_irq
);
    logic             rise, fall;
    logic             pkt_valid;
    logic [PKT_W-1:0] pkt_data;
    side_e            pkt_side;

    i2s_mrx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .sck    (sck_out),
        .rise   (rise),
        .fall   (fall)
    );

    i2s_mrx_framer #(.PKT_W(PKT_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .chan32    (chan32),
        .rise      (rise),
        .fall      (fall),
        .sd_in     (sd_in),
        .ws        (ws_out),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_side  (pkt_side)
    );

    i2s_mrx_rxbuf #(.PKT_W(PKT_W)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_side  (pkt_side),
        .rd_en     (rd_en),
        .st_rd     (st_rd),
        .rd_data   (rd_data),
        .rxne      (rxne),
        .side      (side),
        .ovr       (ovr)
    );

    assign rx_irq  = rxne & rx_ie;
    assign err_irq = ovr & err_ie;
endmodule

// File: rtl/i2s_master_rx_chk.sv
module i2s_master_rx_chk
    import i2s_mrx_pkg::*;
#(
    parameter int PKT_W = i2s_mrx_pkg::PKT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             rd_en,
    input logic             st_rd,
    input logic             rx_ie,
    input logic             err_ie,
    input logic             sck_out,
    input logic             ws_out,
    input logic [PKT_W-1:0] rd_data,
    input logic             rxne,
    input logic             side,
    input logic             ovr,
    input logic             rx_irq,
    input logic             err_irq,
    input logic             pkt_valid,
    input side_e            pkt_side
);
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sck_out);

    a_r2_ws_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ws_out);

    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> rxne);

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !pkt_valid) |=> !rxne);

    a_r5_side_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !(rxne && !rd_en)) |=> (side == $past(pkt_side)));

    a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && rxne && !rd_en) |=> (ovr && rxne && $stable(rd_data) && $stable(side)));

    a_r7_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !st_rd) |=> ovr);

    a_r8_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne && rx_ie) |-> rx_irq);

    a_r8_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (ovr && err_ie));
endmodule

bind i2s_master_rx i2s_master_rx_chk #(.PKT_W(PKT_W)) u_chk (.*);

// File: tb/i2s_master_rx_bench.sv
module i2s_master_rx_bench;
    localparam int HALF = 2;
    localparam int PW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          chan32 = 1'b0;
    logic          rx_ie = 1'b0;
    logic          err_ie = 1'b0;
    logic          rd_en = 1'b0;
    logic          st_rd = 1'b0;
    logic          sd_in = 1'b0;
    logic          sck_out, ws_out, rxne, side, ovr, rx_irq, err_irq;
    logic [PW-1:0] rd_data;

    int tests = 0;
    int fails = 0;
    int rise_cnt = 0;
    int ws_bad = 0;
    int ws_seen = 0;
    int sck_bad = 0;
    int sck_run = 0;
    logic sck_prev = 1'b0;
    logic sck_valid = 1'b0;

    always #4 clk = ~clk;

    i2s_master_rx #(.HALF_DIV(HALF), .PKT_W(PW)) u_i2s_master_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chan32(chan32),
        .rx_ie(rx_ie), .err_ie(err_ie), .rd_en(rd_en), .st_rd(st_rd),
        .sd_in(sd_in), .sck_out(sck_out), .ws_out(ws_out), .rd_data(rd_data),
        .rxne(rxne), .side(side), .ovr(ovr), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    function automatic logic [PW-1:0] pkt_val(input int n);
        if (n % 8 == 3) return '0;
        if (n % 8 == 5) return '1;
        return PW'(n * 16'h3B29) ^ 16'hC6A5;
    endfunction

    function automatic logic stream_bit(input int k);
        int j;
        logic [PW-1:0] w;
        if (k == 0) return 1'b0;
        j = k - 1;
        w = pkt_val(j / PW);
        return w[PW-1-(j % PW)];
    endfunction

    function automatic logic exp_side(input int n, input logic m32);
        return m32 ? logic'((n / 2) % 2) : logic'(n % 2);
    endfunction

    // transmitter model and word-select monitor (R2, R3)
    always @(posedge sck_out or negedge enable) begin
        if (!enable) begin
            rise_cnt <= 0;
        end else begin
            if (ws_out !== logic'((rise_cnt / (chan32 ? 2 * PW : PW)) % 2)) ws_bad++;
            ws_seen++;
            rise_cnt <= rise_cnt + 1;
        end
    end

    always @(negedge sck_out or negedge enable) sd_in <= stream_bit(rise_cnt);

    // bit clock period monitor (R1)
    always @(negedge clk) begin
        if (!enable || !rst_n) begin
            sck_run = 0; sck_valid = 1'b0; sck_prev = 1'b0;
        end else begin
            if (sck_out != sck_prev) begin
                if (sck_valid && sck_run != HALF) sck_bad++;
                sck_valid = 1'b1;
                sck_run = 1;
            end else begin
                sck_run++;
            end
            sck_prev = sck_out;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic pulse_st();
        @(negedge clk) st_rd = 1'b1;
        @(negedge clk) st_rd = 1'b0;
    endtask

    task automatic wait_pkt(input int n);
        while (rise_cnt < PW * n + PW + 1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic restart(input logic m32);
        @(negedge clk) enable = 1'b0;
        repeat (6) @(negedge clk);
        chan32 = m32;
        ws_bad = 0; ws_seen = 0; sck_bad = 0;
        @(negedge clk) enable = 1'b1;
    endtask

    task automatic run_mode(input logic m32, input int npk);
        restart(m32);
        for (int n = 0; n < npk; n++) begin
            wait_pkt(n);
            chk("R4 rxne set", rxne, 1);
            chk("R3 packet data", rd_data, pkt_val(n));
            chk("R5 side", side, exp_side(n, m32));
            chk("R8 rx_irq", rx_irq, rx_ie);
            chk("R6 no overrun", ovr, 0);
            pulse_rd();
            @(negedge clk);
            chk("R4 rxne cleared", rxne, 0);
            chk("R8 rx_irq low", rx_irq, 0);
        end
        chk("R2 ws level per slot", ws_bad, 0);
        chk("R2 ws samples seen", ws_seen > 100, 1);
        chk("R1 sck half period", sck_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 sck", sck_out, 0);
        chk("R9 ws", ws_out, 0);
        chk("R9 rxne", rxne, 0);
        chk("R9 ovr", ovr, 0);
        chk("R9 irqs", {rx_irq, err_irq}, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 idle sck", sck_out, 0);
        chk("R1 idle ws", ws_out, 0);

        rx_ie = 1'b0;
        run_mode(1'b0, 20);
        rx_ie = 1'b1;
        run_mode(1'b1, 20);

        // overrun and two-step clear (R6, R7, R8)
        err_ie = 1'b1;
        restart(1'b0);
        wait_pkt(0);
        chk("R3 first packet", rd_data, pkt_val(0));
        pulse_rd();
        wait_pkt(1);
        wait_pkt(2);
        chk("R6 ovr set", ovr, 1);
        chk("R6 old data kept", rd_data, pkt_val(1));
        chk("R6 old side kept", side, 1);
        chk("R6 rxne kept", rxne, 1);
        chk("R8 err_irq", err_irq, 1);
        pulse_st();
        @(negedge clk);
        chk("R7 status alone keeps ovr", ovr, 1);
        pulse_rd();
        @(negedge clk);
        chk("R7 data read keeps ovr", ovr, 1);
        chk("R4 rxne cleared after ovr read", rxne, 0);
        pulse_st();
        @(negedge clk);
        chk("R7 ovr cleared", ovr, 0);
        chk("R8 err_irq low", err_irq, 0);
        wait_pkt(3);
        chk("R6 next packet delivered", rd_data, pkt_val(3));
        chk("R5 next side", side, 1);
        chk("R7 no new ovr", ovr, 0);
        pulse_rd();

        // disabling stops the bus clock (R1)
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sck_out !== 1'b0 || ws_out !== 1'b0) begin
                chk("R1 disabled lines low", {sck_out, ws_out}, 0);
                break;
            end
        end
        chk("R1 disabled sck", sck_out, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule